// File: doc/BRIEF.md
# Decimal Float Special-Value Handler

This block looks at the two 64-bit decimal floating-point operands of an add, subtract, multiply or divide before any coefficient arithmetic starts. It decides whether the operation has a special outcome, and if so it produces the final word and the exception information. The special outcomes are NaN propagation, invalid operations, division of a finite nonzero value by zero, infinite results, and the signed zero that comes from dividing a finite value by an infinity. When none of these applies, the block raises a normal-path flag. The datapath behind it then computes the finite result.

Two trap-enable inputs control what happens on an exception. An enable of 1 means the exception is signalled: the result is suppressed and a trap flag goes out with it. An enable of 0 means the default value is delivered. Two sticky occurrence bits record every detected condition, whatever the enables are. A clear strobe resets them. The block is one registered stage: a result appears one cycle after its valid input.

Top module: `dfp_special_unit`

## Requirements
- R1: Bit 63 is the sign. Bits 62:58 are the combination field, and bit 57 is the top bit of the exponent continuation. Bits 49:0 are the coefficient continuation. A combination of 11111 is a NaN and 11110 is an infinity. A NaN with bit 57 set is signalling. A finite operand is zero when its leading digit is 0 and bits 49:0 are all zero. The leading digit is 0 when the combination's top two bits are not 11 and its low three bits are 000.
- R2: `o_valid` and all results appear on the clock edge after `i_valid`. After reset, `o_valid` and both occurrence bits are 0.
- R3: A propagated NaN has combination 11111 and an exponent continuation of all zeros. It keeps the sign and bits 49:0 of the operand it came from.
- R4: When a NaN is chosen, a signalling NaN takes precedence over a quiet one. Between NaNs of equal rank, operand A (`i_a`) is chosen.
- R5: A signalling NaN operand raises invalid. If the invalid trap is disabled, its quiet form is delivered.
- R6: The following cases raise invalid: infinities of opposite sign under add, infinities of like sign under subtract, zero times infinity in either order, zero divided by zero, and infinity divided by infinity. With the trap disabled, these deliver 0x7C00_0000_0000_0000.
- R7: A finite nonzero dividend over a zero divisor raises zero-divide. With that trap disabled, the result is an infinity whose sign is the XOR of the operand signs.
- R8: An infinite result has all of bits 57:0 zero, whatever the infinite operand held there. Add takes the infinite operand's sign. Subtract takes A's sign, or the inverted sign of B when only B is infinite. Multiply and divide take the XOR of the signs.
- R9: A finite dividend over an infinite divisor gives a zero whose sign is the XOR of the signs and whose other bits are all zero.
- R10: When no special case applies, `o_normal` is 1, `o_result` is zero and no trap flag is set.
- R11: An occurrence bit is set whenever its condition is detected, regardless of its trap enable. It holds until `i_clr`. A detection in the same cycle as `i_clr` leaves the bit set.
- R12: When an enabled trap fires, `o_suppressed` and the matching trap flag are 1 and `o_result` is zero. At most one trap flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_valid | input | 1 | Operands and operation are present |
| i_op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 divide |
| i_a | input | 64 | Operand A (dividend, minuend) |
| i_b | input | 64 | Operand B (divisor, subtrahend) |
| i_trap_en_inv | input | 1 | 1 signals invalid instead of delivering a default |
| i_trap_en_zdiv | input | 1 | 1 signals zero-divide instead of delivering infinity |
| i_clr | input | 1 | Clears both occurrence bits |
| o_valid | output | 1 | Result registers hold a new decision |
| o_result | output | 64 | Special result word, zero when normal or suppressed |
| o_normal | output | 1 | No special case; the finite datapath owns the result |
| o_suppressed | output | 1 | An enabled trap fired; the result is withheld |
| o_trap_inv | output | 1 | Invalid exception signalled |
| o_trap_zdiv | output | 1 | Zero-divide exception signalled |
| o_occ_inv | output | 1 | Sticky invalid occurrence |
| o_occ_zdiv | output | 1 | Sticky zero-divide occurrence |

## Verification
Every operation code is exercised with pairs of finite, zero, infinite, quiet NaN and signalling NaN operands. Each pair tells the rules apart by the sign and the fields the result carries. NaN pairs are ordered both ways to separate the rank rule from the tie rule. Infinities with nonzero trailing bits show that those bits are cleared. Zero-looking encodings, including one with leading digit 8 and an empty continuation, separate a zero from a nonzero value. Each exception case runs with its trap both enabled and disabled. The occurrence bits are read between operations, around clear strobes, and with a clear in the same cycle as a detection.

// File: rtl/dfp_sv_pkg.sv
package dfp_sv_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MUL = 2'd2,
      OP_DIV = 2'd3
   } dfp_op_e;

   typedef struct packed {
      logic sgn;
      logic is_nan;
      logic is_snan;
      logic is_inf;
      logic is_zero;
   } dfp_cls_t;

   localparam int unsigned CF_W   = 5;
   localparam logic [4:0]  CF_NAN = 5'b11111;
   localparam logic [4:0]  CF_INF = 5'b11110;
endpackage

// File: rtl/dfp_classify.sv
module dfp_classify
   import dfp_sv_pkg::*;
#(
   parameter int unsigned W     = 64,
   parameter int unsigned BEC_W = 8,
   parameter int unsigned CC_W  = 50
) (
   input  logic [W-1:0] word,
   output dfp_cls_t     cls
);
   localparam int unsigned CF_HI  = W - 2;
   localparam int unsigned BEC_HI = W - 2 - CF_W;

   logic [CF_W-1:0] cf;
   logic            lead_zero;
   logic            special;

   assign cf        = word[CF_HI -: CF_W];
   assign special   = (cf[4:1] == 4'b1111);
   assign lead_zero = (cf[4:3] != 2'b11) && (cf[2:0] == 3'b000);

   assign cls.sgn     = word[W-1];
   assign cls.is_nan  = (cf == CF_NAN);
   assign cls.is_snan = (cf == CF_NAN) && word[BEC_HI];
   assign cls.is_inf  = (cf == CF_INF);
   assign cls.is_zero = !special && lead_zero && (word[CC_W-1:0] == '0);

   generate
      if (BEC_W > 1) begin : g_tail
         logic bec_tail_unused;
         assign bec_tail_unused = ^word[BEC_HI-1:CC_W];
      end
   endgenerate
endmodule

// File: rtl/dfp_nan_pick.sv
module dfp_nan_pick
   import dfp_sv_pkg::*;
#(
   parameter int unsigned W     = 64,
   parameter int unsigned BEC_W = 8,
   parameter int unsigned CC_W  = 50
) (
   input  logic            a_nan,
   input  logic            a_snan,
   input  logic            b_snan,
   input  logic            a_sgn,
   input  logic            b_sgn,
   input  logic [CC_W-1:0] a_cc,
   input  logic [CC_W-1:0] b_cc,
   output logic [W-1:0]    qnan
);
   logic pick_b;

   // signalling rank first, then operand A on a tie
   assign pick_b = b_snan ? !a_snan : !a_nan;

   assign qnan = {pick_b ? b_sgn : a_sgn, CF_NAN, {BEC_W{1'b0}},
                  pick_b ? b_cc : a_cc};
endmodule

// File: rtl/dfp_case_resolve.sv
module dfp_case_resolve
   import dfp_sv_pkg::*;
#(
   parameter int unsigned W = 64
) (
   input  dfp_op_e      op,
   input  dfp_cls_t     ca,
   input  dfp_cls_t     cb,
   input  logic         en_inv,
   input  logic         en_zdiv,
   input  logic [W-1:0] nan_word,
   output logic [W-1:0] res,
   output logic         normal,
   output logic         suppress,
   output logic         det_inv,
   output logic         det_zdiv
);
   localparam int unsigned TAIL_W = W - 1 - CF_W;
   localparam logic [W-1:0] DEF_QNAN = {1'b0, CF_NAN, {TAIL_W{1'b0}}};

   logic sx;
   logic any_nan, any_snan;
   logic bad_arith;
   logic inf_res, inf_sgn;
   logic zero_res;
   logic zdiv;

   assign sx       = ca.sgn ^ cb.sgn;
   assign any_nan  = ca.is_nan | cb.is_nan;
   assign any_snan = ca.is_snan | cb.is_snan;

   always_comb begin
      bad_arith = 1'b0;
      inf_res   = 1'b0;
      inf_sgn   = sx;
      zero_res  = 1'b0;
      zdiv      = 1'b0;
      unique case (op)
         OP_ADD: begin
            bad_arith = ca.is_inf & cb.is_inf & sx;
            inf_res   = ca.is_inf | cb.is_inf;
            inf_sgn   = ca.is_inf ? ca.sgn : cb.sgn;
         end
         OP_SUB: begin
            bad_arith = ca.is_inf & cb.is_inf & !sx;
            inf_res   = ca.is_inf | cb.is_inf;
            inf_sgn   = ca.is_inf ? ca.sgn : !cb.sgn;
         end
         OP_MUL: begin
            bad_arith = (ca.is_zero & cb.is_inf) | (ca.is_inf & cb.is_zero);
            inf_res   = ca.is_inf | cb.is_inf;
         end
         OP_DIV: begin
            bad_arith = (ca.is_zero & cb.is_zero) | (ca.is_inf & cb.is_inf);
            inf_res   = ca.is_inf;
            zero_res  = cb.is_inf & !ca.is_inf;
            zdiv      = cb.is_zero & !ca.is_zero & !ca.is_inf;
         end
         default: ;
      endcase
   end

   always_comb begin
      res      = '0;
      normal   = 1'b0;
      suppress = 1'b0;
      det_inv  = 1'b0;
      det_zdiv = 1'b0;
      if (any_nan) begin
         det_inv  = any_snan;
         suppress = any_snan & en_inv;
         res      = suppress ? '0 : nan_word;
      end else if (bad_arith) begin
         det_inv  = 1'b1;
         suppress = en_inv;
         res      = en_inv ? '0 : DEF_QNAN;
      end else if (inf_res) begin
         res = {inf_sgn, CF_INF, {TAIL_W{1'b0}}};
      end else if (zero_res) begin
         res = {sx, {(W-1){1'b0}}};
      end else if (zdiv) begin
         det_zdiv = 1'b1;
         suppress = en_zdiv;
         res      = en_zdiv ? '0 : {sx, CF_INF, {TAIL_W{1'b0}}};
      end else begin
         normal = 1'b1;
      end
   end
endmodule

// File: rtl/dfp_special_unit.sv
module dfp_special_unit
   import dfp_sv_pkg::*;
#(
   parameter int unsigned W     = 64,
   parameter int unsigned BEC_W = 8,
   parameter int unsigned CC_W  = 50
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         i_valid,
   input  logic [1:0]   i_op,
   input  logic [W-1:0] i_a,
   input  logic [W-1:0] i_b,
   input  logic         i_trap_en_inv,
   input  logic         i_trap_en_zdiv,
   input  logic         i_clr,
   output logic         o_valid,
   output logic [W-1:0] o_result,
   output logic         o_normal,
   output logic         o_suppressed,
   output logic         o_trap_inv,
   output logic         o_trap_zdiv,
   output logic         o_occ_inv,
   output logic         o_occ_zdiv
);
   localparam int unsigned N_OPND = 2;

   generate
      if (1 + CF_W + BEC_W + CC_W != W) begin : g_bad_layout
         $error("field widths do not add up to W");
      end
      if (BEC_W < 1 || CC_W < 1) begin : g_bad_fields
         $error("continuation fields must be at least one bit");
      end
   endgenerate

   logic [W-1:0] opnd [N_OPND];
   dfp_cls_t     cls  [N_OPND];

   assign opnd[0] = i_a;
   assign opnd[1] = i_b;

   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_cls
         dfp_classify #(.W(W), .BEC_W(BEC_W), .CC_W(CC_W)) u_cls (
            .word (opnd[g]),
            .cls  (cls[g])
         );
      end
   endgenerate

   logic [W-1:0] nan_word;

   dfp_nan_pick #(.W(W), .BEC_W(BEC_W), .CC_W(CC_W)) u_pick (
      .a_nan  (cls[0].is_nan),
      .a_snan (cls[0].is_snan),
      .b_snan (cls[1].is_snan),
      .a_sgn  (cls[0].sgn),
      .b_sgn  (cls[1].sgn),
      .a_cc   (i_a[CC_W-1:0]),
      .b_cc   (i_b[CC_W-1:0]),
      .qnan   (nan_word)
   );

   logic [W-1:0] res_c;
   logic         normal_c, supp_c, inv_c, zdiv_c;

   dfp_case_resolve #(.W(W)) u_res (
      .op       (dfp_op_e'(i_op)),
      .ca       (cls[0]),
      .cb       (cls[1]),
      .en_inv   (i_trap_en_inv),
      .en_zdiv  (i_trap_en_zdiv),
      .nan_word (nan_word),
      .res      (res_c),
      .normal   (normal_c),
      .suppress (supp_c),
      .det_inv  (inv_c),
      .det_zdiv (zdiv_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid      <= 1'b0;
         o_result     <= '0;
         o_normal     <= 1'b0;
         o_suppressed <= 1'b0;
         o_trap_inv   <= 1'b0;
         o_trap_zdiv  <= 1'b0;
         o_occ_inv    <= 1'b0;
         o_occ_zdiv   <= 1'b0;
      end else begin
         o_valid <= i_valid;
         if (i_valid) begin
            o_result     <= res_c;
            o_normal     <= normal_c;
            o_suppressed <= supp_c;
            o_trap_inv   <= inv_c & i_trap_en_inv;
            o_trap_zdiv  <= zdiv_c & i_trap_en_zdiv;
         end
         o_occ_inv  <= (o_occ_inv & !i_clr) | (i_valid & inv_c);
         o_occ_zdiv <= (o_occ_zdiv & !i_clr) | (i_valid & zdiv_c);
      end
   end
endmodule

// File: rtl/dfp_special_unit_chk.sv
module dfp_special_unit_chk #(
   parameter int unsigned W     = 64,
   parameter int unsigned BEC_W = 8,
   parameter int unsigned CC_W  = 50
) (
   input logic         clk,
   input logic         rst_n,
   input logic         i_valid,
   input logic         i_clr,
   input logic         o_valid,
   input logic [W-1:0] o_result,
   input logic         o_normal,
   input logic         o_suppressed,
   input logic         o_trap_inv,
   input logic         o_trap_zdiv,
   input logic         o_occ_inv,
   input logic         o_occ_zdiv
);
   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      i_valid |=> o_valid); // R2
   AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> !o_valid); // R2
   AST_NAN_BEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_suppressed && o_result[W-2 -: 5] == 5'b11111)
      |-> (o_result[W-7 -: BEC_W] == '0)); // R3
   AST_TRAP_SETS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_trap_inv) |-> o_occ_inv); // R5
   AST_INF_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_suppressed && o_result[W-2 -: 5] == 5'b11110)
      |-> (o_result[W-7:0] == '0)); // R8
   AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_normal) |-> (!o_suppressed && !o_trap_inv && !o_trap_zdiv && o_result == '0)); // R10
   AST_OCC_INV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (o_occ_inv && !i_clr) |=> o_occ_inv); // R11
   AST_OCC_ZDIV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (o_occ_zdiv && !i_clr) |=> o_occ_zdiv); // R11
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (i_clr && !i_valid) |=> (!o_occ_inv && !o_occ_zdiv)); // R11
   AST_TRAP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && (o_trap_inv || o_trap_zdiv)) |-> (o_suppressed && o_result == '0)); // R12
   AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> $onehot0({o_trap_inv, o_trap_zdiv})); // R12
endmodule

bind dfp_special_unit dfp_special_unit_chk #(.W(W), .BEC_W(BEC_W), .CC_W(CC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .i_valid      (i_valid),
   .i_clr        (i_clr),
   .o_valid      (o_valid),
   .o_result     (o_result),
   .o_normal     (o_normal),
   .o_suppressed (o_suppressed),
   .o_trap_inv   (o_trap_inv),
   .o_trap_zdiv  (o_trap_zdiv),
   .o_occ_inv    (o_occ_inv),
   .o_occ_zdiv   (o_occ_zdiv)
);

// File: tb/dfp_special_unit_tb.sv
module dfp_special_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   localparam logic [63:0] ZP  = 64'h2238_0000_0000_0000;
   localparam logic [63:0] ZN  = 64'hA238_0000_0000_0000;
   localparam logic [63:0] Z00 = 64'h0000_0000_0000_0000;
   localparam logic [63:0] F1  = 64'h2238_0000_0000_0005;
   localparam logic [63:0] F8  = 64'h6000_0000_0000_0000;
   localparam logic [63:0] PI  = 64'h7800_0000_0000_0000;
   localparam logic [63:0] NI  = 64'hF800_0000_0000_0000;
   localparam logic [63:0] NIJ = 64'hF800_0000_0000_1234;
   localparam logic [63:0] QA  = 64'h7D00_0000_0000_0ABC;
   localparam logic [63:0] QAQ = 64'h7C00_0000_0000_0ABC;
   localparam logic [63:0] QB  = 64'h7C00_0000_0000_0777;
   localparam logic [63:0] SB  = 64'hFE00_0000_0000_0321;
   localparam logic [63:0] SBQ = 64'hFC00_0000_0000_0321;
   localparam logic [63:0] DQ  = 64'h7C00_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_valid = 1'b0;
   logic [1:0]  i_op = 2'd0;
   logic [63:0] i_a = '0;
   logic [63:0] i_b = '0;
   logic        i_trap_en_inv = 1'b0;
   logic        i_trap_en_zdiv = 1'b0;
   logic        i_clr = 1'b0;
   logic        o_valid;
   logic [63:0] o_result;
   logic        o_normal, o_suppressed, o_trap_inv, o_trap_zdiv;
   logic        o_occ_inv, o_occ_zdiv;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct packed {
      logic [63:0] res;
      logic        nrm;
      logic        sup;
      logic        ti;
      logic        tz;
   } exp_t;

   exp_t  exp_q [$];
   string tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dfp_special_unit u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .i_valid        (i_valid),
      .i_op           (i_op),
      .i_a            (i_a),
      .i_b            (i_b),
      .i_trap_en_inv  (i_trap_en_inv),
      .i_trap_en_zdiv (i_trap_en_zdiv),
      .i_clr          (i_clr),
      .o_valid        (o_valid),
      .o_result       (o_result),
      .o_normal       (o_normal),
      .o_suppressed   (o_suppressed),
      .o_trap_inv     (o_trap_inv),
      .o_trap_zdiv    (o_trap_zdiv),
      .o_occ_inv      (o_occ_inv),
      .o_occ_zdiv     (o_occ_zdiv)
   );

   task automatic check_bit(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic ei, input logic ez, input logic clr,
                        input logic [63:0] eres, input logic enrm, input logic esup,
                        input logic eti, input logic etz, input string tag);
      exp_t e;
      @(negedge clk);
      i_valid = 1'b1; i_op = op; i_a = a; i_b = b;
      i_trap_en_inv = ei; i_trap_en_zdiv = ez; i_clr = clr;
      e.res = eres; e.nrm = enrm; e.sup = esup; e.ti = eti; e.tz = etz;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input logic clr);
      @(negedge clk);
      i_valid = 1'b0; i_clr = clr;
   endtask

   // monitor: compares each produced result with the oldest expected item
   always @(negedge clk) begin
      if (rst_n && o_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R2: unexpected result actual=%h expected=none", o_result);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({o_result, o_normal, o_suppressed, o_trap_inv, o_trap_zdiv} !== e) begin
               bad++;
               $display("FAIL %s: actual=%h n%0b s%0b ti%0b tz%0b expected=%h n%0b s%0b ti%0b tz%0b",
                        t, o_result, o_normal, o_suppressed, o_trap_inv, o_trap_zdiv,
                        e.res, e.nrm, e.sup, e.ti, e.tz);
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_bit("R2 reset o_valid", o_valid, 1'b0);
      check_bit("R2 reset occ_inv", o_occ_inv, 1'b0);
      check_bit("R2 reset occ_zdiv", o_occ_zdiv, 1'b0);
      rst_n = 1'b1;

      // R10 finite operands take the normal path; no occurrence
      drive(2'd0, F1, F8, 0, 0, 0, '0, 1, 0, 0, 0, "R10 add finite");
      idle(0); idle(0);
      check_bit("R10 occ_inv after normal", o_occ_inv, 1'b0);

      // R7 and R11: masked zero-divide still records an occurrence
      drive(2'd3, F8, ZN, 0, 0, 0, NI, 0, 0, 0, 0, "R7 masked zdiv, R1 lead digit 8 nonzero");
      idle(0); idle(0);
      check_bit("R11 occ_zdiv set while masked", o_occ_zdiv, 1'b1);
      check_bit("R11 occ_inv untouched", o_occ_inv, 1'b0);
      idle(1); idle(0);
      check_bit("R11 clear zdiv", o_occ_zdiv, 1'b0);

      // R11: detection in the clear cycle wins
      drive(2'd2, F1, SB, 0, 0, 1, SBQ, 0, 0, 0, 0, "R5 masked snan quieted");
      idle(0); idle(0); idle(0);
      check_bit("R11 detect beats clear", o_occ_inv, 1'b1);
      check_bit("R11 occ_inv sticky", o_occ_inv, 1'b1);
      idle(1); idle(0);

      // NaN propagation and preference
      drive(2'd0, QA, F1, 0, 0, 0, QAQ, 0, 0, 0, 0, "R3 qnan bec cleared");
      drive(2'd0, QA, SB, 0, 0, 0, SBQ, 0, 0, 0, 0, "R4 snan beats qnan");
      drive(2'd0, QA, QB, 0, 0, 0, QAQ, 0, 0, 0, 0, "R4 tie picks A");
      drive(2'd1, QB, QA, 0, 0, 0, QB, 0, 0, 0, 0, "R4 tie picks A swapped");
      drive(2'd3, SB, F1, 1, 0, 0, '0, 0, 1, 1, 0, "R5 R12 snan trapped");
      idle(0); idle(0);
      check_bit("R5 trapped snan sets occ_inv", o_occ_inv, 1'b1);
      idle(1); idle(0);

      // invalid combinations
      drive(2'd0, PI, NI, 0, 0, 0, DQ, 0, 0, 0, 0, "R6 inf add opposite");
      drive(2'd1, PI, PI, 0, 0, 0, DQ, 0, 0, 0, 0, "R6 inf sub like");
      drive(2'd2, ZP, NI, 0, 0, 0, DQ, 0, 0, 0, 0, "R6 zero times inf");
      drive(2'd2, NI, ZP, 0, 0, 0, DQ, 0, 0, 0, 0, "R6 inf times zero");
      drive(2'd3, ZN, ZP, 0, 0, 0, DQ, 0, 0, 0, 0, "R6 zero over zero");
      drive(2'd3, Z00, Z00, 0, 0, 0, DQ, 0, 0, 0, 0, "R1 R6 all-zero word is zero");
      drive(2'd3, PI, NI, 1, 0, 0, '0, 0, 1, 1, 0, "R12 inf over inf trapped");

      // infinity results
      drive(2'd1, PI, NI, 0, 0, 0, PI, 0, 0, 0, 0, "R8 sub inf a sign");
      drive(2'd1, F1, PI, 0, 0, 0, NI, 0, 0, 0, 0, "R8 sub inf b inverted");
      drive(2'd0, F1, NIJ, 0, 0, 0, NI, 0, 0, 0, 0, "R8 tail bits cleared");
      drive(2'd2, NI, F8, 0, 0, 0, NI, 0, 0, 0, 0, "R8 mul xor sign");
      drive(2'd3, NI, F1, 0, 0, 0, NI, 0, 0, 0, 0, "R8 div inf dividend");
      drive(2'd3, PI, ZP, 0, 1, 0, PI, 0, 0, 0, 0, "R8 inf over zero no zdiv");
      drive(2'd3, F1, NI, 0, 0, 0, 64'h8000_0000_0000_0000, 0, 0, 0, 0, "R9 finite over inf");
      drive(2'd3, F1, ZP, 0, 1, 0, '0, 0, 1, 0, 1, "R7 R12 zdiv trapped");
      drive(2'd2, F1, ZP, 1, 1, 0, '0, 1, 0, 0, 0, "R10 mul by zero normal");
      idle(0); idle(0); idle(0);
      check_bit("R11 occ_zdiv after trapped zdiv", o_occ_zdiv, 1'b1);

      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R2: pending results actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule